// File: doc/BRIEF.md
# Multiplexed-Address DRAM Array with Row Buffer

This block is a synchronous behavioural model of a small DRAM array. It holds `ROWS x COLS` supercells, each `W` bits wide, in a two-dimensional grid of registers. Row and column numbers arrive one after the other on one narrow address bus. A row strobe opens a row: the block copies the whole row into an internal row buffer. Each column strobe that follows picks one supercell out of that buffer. A read strobe places the supercell on the read port one clock later. A write strobe changes the supercell in the buffer. An edited row goes back to the grid when the row is closed by a precharge, or when another activation replaces it. A single activation can serve any number of column strobes.

A two-state controller tracks whether a row is open. In state CLOSED no row is held. The transition OPEN_ROW, taken on an activation, moves it to OPEN. In state OPEN a row is held in the buffer. The transition REOPEN (an activation while OPEN) writes the held row back and loads the new one, and the state stays OPEN. The transition CLOSE_ROW (a precharge while OPEN) writes the row back and returns to CLOSED. Every other command leaves the state where it is. A column strobe issued in CLOSED raises an error pulse instead of returning data.

Top module: `mdram_core`

## Requirements
- R1: After reset no row is open, `rvalid` and `err` are 0, `rdata` is 0, and every supercell holds 0.
- R2: `row_stb` (with `pre_stb` low) opens the row given by the low row-index bits of `addr`, and a later read of any column of it returns the stored supercell.
- R3: While a row is open, any number of column strobes may follow one activation, and between activations and writes the row buffer holds its contents.
- R4: A read (`col_stb`=1, `wr_en`=0) to an open row gives `rvalid`=1 and the supercell on `rdata` exactly one clock after the strobe edge, for one cycle. `rdata` is 0 whenever `rvalid` is 0.
- R5: A write (`col_stb`=1, `wr_en`=1) to an open row replaces that column's supercell in the buffer with `wdata` and raises neither `rvalid` nor `err`.
- R6: A precharge writes the open row's buffer back into the grid, so the data is still there when the row is opened again.
- R7: An activation while a row is open first writes the open row back. If the same row is activated again, the edits made in the buffer are kept.
- R8: A column strobe while no row is open gives `err`=1 for one cycle one clock later, with `rvalid`=0, and a write strobe in that state changes no supercell.
- R9: When several strobes are high in one cycle, precharge wins over activation, and activation wins over a column strobe. The losing strobes have no effect.
- R10: A precharge while no row is open has no effect on the outputs or on the stored data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_stb | input | 1 | Activate: latch the row number from `addr` and load that row |
| col_stb | input | 1 | Column strobe: read or write one supercell of the open row |
| wr_en | input | 1 | With `col_stb`: 1 = write `wdata`, 0 = read |
| pre_stb | input | 1 | Precharge: write back and close the open row |
| addr | input | AW | Multiplexed row or column number (AW = 2 by default) |
| wdata | input | W | Write data for a column write |
| rdata | output | W | Read data, valid with `rvalid`, else 0 |
| rvalid | output | 1 | One-cycle pulse marking valid read data |
| err | output | 1 | One-cycle pulse: column strobe with no row open |

## Verification
The assertions assume that the strobes are sampled as plain levels on each rising edge, with no minimum gap between them. They also assume that `addr` always names an existing row or column, which the default power-of-two grid guarantees. The stimulus changes inputs only on falling edges. It draws addresses only over the full `AW`-bit range of the default grid, and mixes the strobes freely, including several at once. This way the priority rule and the column-strobe-while-closed path are both exercised from every state.

// File: rtl/mdram_pkg.sv
package mdram_pkg;

    typedef enum logic {
        ST_CLOSED = 1'b0,
        ST_OPEN   = 1'b1
    } bank_state_e;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_PRE = 3'd1,
        CMD_ACT = 3'd2,
        CMD_RD  = 3'd3,
        CMD_WR  = 3'd4
    } dram_cmd_e;

endpackage

// File: rtl/mdram_cmd_decode.sv
module mdram_cmd_decode
    import mdram_pkg::*;
(
    input  logic      pre_stb,
    input  logic      row_stb,
    input  logic      col_stb,
    input  logic      wr_en,
    output dram_cmd_e cmd
);

    // Fixed priority: precharge, then activate, then column access.
    always_comb begin
        if (pre_stb)      cmd = CMD_PRE;
        else if (row_stb) cmd = CMD_ACT;
        else if (col_stb) cmd = wr_en ? CMD_WR : CMD_RD;
        else              cmd = CMD_NOP;
    end

endmodule

// File: rtl/mdram_cell_array.sv
module mdram_cell_array #(
    parameter int ROWS = 4,
    parameter int COLS = 4,
    parameter int W    = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [((ROWS>1)?$clog2(ROWS):1)-1:0] rd_row,
    output logic [COLS*W-1:0]             rd_data,
    input  logic                          wb_en,
    input  logic [((ROWS>1)?$clog2(ROWS):1)-1:0] wb_row,
    input  logic [COLS*W-1:0]             wb_data
);

    localparam int RB = (ROWS > 1) ? $clog2(ROWS) : 1;
    localparam int RW = COLS * W;

    logic [RW-1:0] row_q [ROWS];

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                row_q[r] <= '0;
            else if (wb_en && (wb_row == RB'(r)))
                row_q[r] <= wb_data;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int r = 0; r < ROWS; r++)
            if (rd_row == RB'(r)) rd_data = row_q[r];
    end

    AST_WB_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |=> row_q[$past(wb_row)] == $past(wb_data)); // R6

endmodule

// File: rtl/mdram_row_buffer.sv
module mdram_row_buffer #(
    parameter int COLS = 4,
    parameter int W    = 8
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  load_en,
    input  logic [COLS*W-1:0]                     load_data,
    input  logic                                  wr_en,
    input  logic [((COLS>1)?$clog2(COLS):1)-1:0]  col,
    input  logic [W-1:0]                          wdata,
    output logic [COLS*W-1:0]                     buf_data,
    output logic [W-1:0]                          col_data
);

    localparam int CB = (COLS > 1) ? $clog2(COLS) : 1;

    logic [W-1:0] cell_q [COLS];

    for (genvar c = 0; c < COLS; c++) begin : g_col
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cell_q[c] <= '0;
            else if (load_en)
                cell_q[c] <= load_data[c*W +: W];
            else if (wr_en && (col == CB'(c)))
                cell_q[c] <= wdata;
        end
        assign buf_data[c*W +: W] = cell_q[c];
    end

    always_comb begin
        col_data = '0;
        for (int c = 0; c < COLS; c++)
            if (col == CB'(c)) col_data = cell_q[c];
    end

    AST_BUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !wr_en) |=> $stable(buf_data)); // R3

endmodule

// File: rtl/mdram_core.sv
module mdram_core
    import mdram_pkg::*;
#(
    parameter int ROWS = 4,
    parameter int COLS = 4,
    parameter int W    = 8,
    localparam int RB  = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int CB  = (COLS > 1) ? $clog2(COLS) : 1,
    localparam int AW  = (RB > CB) ? RB : CB
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          row_stb,
    input  logic          col_stb,
    input  logic          wr_en,
    input  logic          pre_stb,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata,
    output logic          rvalid,
    output logic          err
);

    localparam int RW = COLS * W;

    bank_state_e   state_q, state_d;
    dram_cmd_e     cmd;
    logic [RB-1:0] open_row_q;
    logic [RB-1:0] addr_row;
    logic [CB-1:0] addr_col;
    logic [RW-1:0] arr_rd;
    logic [RW-1:0] buf_data;
    logic [RW-1:0] load_data;
    logic [W-1:0]  col_data;
    logic          is_open;
    logic          wb_en;
    logic          load_en;
    logic          buf_wr;

    assign addr_row = addr[RB-1:0];
    assign addr_col = addr[CB-1:0];
    assign is_open  = (state_q == ST_OPEN);

    mdram_cmd_decode u_dec (
        .pre_stb (pre_stb),
        .row_stb (row_stb),
        .col_stb (col_stb),
        .wr_en   (wr_en),
        .cmd     (cmd)
    );

    // Write back the held row whenever it is closed or replaced.
    assign wb_en   = is_open && ((cmd == CMD_PRE) || (cmd == CMD_ACT));
    assign load_en = (cmd == CMD_ACT);
    assign buf_wr  = is_open && (cmd == CMD_WR);
    // Reopening the held row keeps the buffer's edits.
    assign load_data = (is_open && (addr_row == open_row_q)) ? buf_data : arr_rd;

    mdram_cell_array #(.ROWS(ROWS), .COLS(COLS), .W(W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_row  (addr_row),
        .rd_data (arr_rd),
        .wb_en   (wb_en),
        .wb_row  (open_row_q),
        .wb_data (buf_data)
    );

    mdram_row_buffer #(.COLS(COLS), .W(W)) u_rowbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_en),
        .load_data (load_data),
        .wr_en     (buf_wr),
        .col       (addr_col),
        .wdata     (wdata),
        .buf_data  (buf_data),
        .col_data  (col_data)
    );

    // Next state: OPEN_ROW, REOPEN, CLOSE_ROW.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLOSED: if (cmd == CMD_ACT) state_d = ST_OPEN;
            ST_OPEN:   if (cmd == CMD_PRE) state_d = ST_CLOSED;
            default:   state_d = ST_CLOSED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_CLOSED;
            open_row_q <= '0;
        end else begin
            state_q <= state_d;
            if (cmd == CMD_ACT) open_row_q <= addr_row;
        end
    end

    // Registered outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            rdata  <= '0;
            err    <= 1'b0;
        end else begin
            rvalid <= is_open && (cmd == CMD_RD);
            rdata  <= (is_open && (cmd == CMD_RD)) ? col_data : '0;
            err    <= !is_open && ((cmd == CMD_RD) || (cmd == CMD_WR));
        end
    end

    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (col_stb && !wr_en && !row_stb && !pre_stb && is_open)
        |=> (rvalid && rdata == $past(col_data))); // R4
    AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rvalid |-> (rdata == '0)); // R4
    AST_CLOSED_CAS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (col_stb && !row_stb && !pre_stb && !is_open) |=> (err && !rvalid)); // R8
    AST_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(err && rvalid)); // R8
    AST_PRE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        pre_stb |=> (!is_open && !rvalid && !err)); // R9
    AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (col_stb && wr_en && !row_stb && !pre_stb && is_open) |=> (!rvalid && !err)); // R5

endmodule

// File: tb/sim_mdram_core.sv
module sim_mdram_core;

    localparam int CLK_PERIOD = 10;
    localparam int ROWS = 4;
    localparam int COLS = 4;
    localparam int W    = 8;
    localparam int AW   = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          row_stb = 1'b0, col_stb = 1'b0, wr_en = 1'b0, pre_stb = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [W-1:0]  wdata = '0;
    logic [W-1:0]  rdata;
    logic          rvalid, err;

    int total = 0;
    int bad   = 0;

    // Reference state built from the requirements.
    logic [W-1:0] m_mem [ROWS][COLS];
    logic [W-1:0] m_buf [COLS];
    logic         m_open = 1'b0;
    int           m_row  = 0;

    logic         e_valid = 1'b0, e_err = 1'b0;
    logic [W-1:0] e_data = '0;
    string        e_tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    mdram_core #(.ROWS(ROWS), .COLS(COLS), .W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .row_stb(row_stb), .col_stb(col_stb),
        .wr_en(wr_en), .pre_stb(pre_stb), .addr(addr), .wdata(wdata),
        .rdata(rdata), .rvalid(rvalid), .err(err)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic check_pending();
        chk(rvalid == e_valid, e_tag, "rvalid", int'(rvalid), int'(e_valid));
        chk(err == e_err, e_tag, "err", int'(err), int'(e_err));
        chk(rdata == e_data, e_tag, "rdata", int'(rdata), int'(e_data));
    endtask

    // Drive one command at a falling edge after checking the previous one.
    task automatic issue(input bit p, input bit ra, input bit ca, input bit w,
                         input int a, input logic [W-1:0] d, input string tag);
        @(negedge clk);
        check_pending();
        pre_stb = p; row_stb = ra; col_stb = ca; wr_en = w;
        addr = AW'(a); wdata = d;
        e_valid = 1'b0; e_err = 1'b0; e_data = '0; e_tag = tag;
        if (p) begin
            if (m_open) for (int c = 0; c < COLS; c++) m_mem[m_row][c] = m_buf[c];
            m_open = 1'b0;
        end else if (ra) begin
            if (m_open) for (int c = 0; c < COLS; c++) m_mem[m_row][c] = m_buf[c];
            for (int c = 0; c < COLS; c++) m_buf[c] = m_mem[a][c];
            m_row = a; m_open = 1'b1;
        end else if (ca) begin
            if (!m_open) e_err = 1'b1;
            else if (w) m_buf[a] = d;
            else begin e_valid = 1'b1; e_data = m_buf[a]; end
        end
    endtask

    task automatic nop(input string tag);
        issue(0, 0, 0, 0, 0, 8'h00, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) m_mem[r][c] = '0;
        for (int c = 0; c < COLS; c++) m_buf[c] = '0;
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: idle outputs after reset
        nop("R1");
        // R8: column strobes with no row open, write must not land
        issue(0, 0, 1, 0, 2, 8'h00, "R8");
        issue(0, 0, 1, 1, 1, 8'hA5, "R8");
        // R10: precharge while closed
        issue(1, 0, 0, 0, 0, 8'h00, "R10");
        nop("R10");
        // R1/R8: row 0 still all zero
        issue(0, 1, 0, 0, 0, 8'h00, "R2");
        issue(0, 0, 1, 0, 1, 8'h00, "R8");
        issue(0, 0, 1, 0, 0, 8'h00, "R1");
        // R5/R3: fill row 1, then RAS CAS CAS CAS
        issue(0, 1, 0, 0, 1, 8'h00, "R2");
        for (int c = 0; c < COLS; c++) issue(0, 0, 1, 1, c, 8'h10 + 8'(c), "R5");
        for (int c = COLS - 1; c >= 0; c--) issue(0, 0, 1, 0, c, 8'h00, "R3");
        // R4: read then idle, pulse lasts one cycle
        issue(0, 0, 1, 0, 2, 8'h00, "R4");
        nop("R4");
        nop("R4");
        // R6: precharge then reopen
        issue(1, 0, 0, 0, 0, 8'h00, "R6");
        issue(0, 1, 0, 0, 1, 8'h00, "R6");
        issue(0, 0, 1, 0, 3, 8'h00, "R6");
        // R7: write row 2, activate row 3 without precharge, back to row 2
        issue(0, 1, 0, 0, 2, 8'h00, "R7");
        issue(0, 0, 1, 1, 3, 8'hC3, "R7");
        issue(0, 1, 0, 0, 3, 8'h00, "R7");
        issue(0, 1, 0, 0, 2, 8'h00, "R7");
        issue(0, 0, 1, 0, 3, 8'h00, "R7");
        // R7: reactivate the same row keeps buffer edits
        issue(0, 0, 1, 1, 0, 8'h7E, "R7");
        issue(0, 1, 0, 0, 2, 8'h00, "R7");
        issue(0, 0, 1, 0, 0, 8'h00, "R7");
        // R9: all strobes together -> precharge only
        issue(1, 1, 1, 1, 1, 8'hFF, "R9");
        issue(0, 0, 1, 0, 0, 8'h00, "R9");
        // R9: activate plus write -> activate only, write dropped
        issue(0, 1, 1, 1, 1, 8'h99, "R9");
        issue(0, 0, 1, 0, 1, 8'h00, "R9");
        // R2: back-to-back read after write of same column
        issue(0, 0, 1, 1, 0, 8'h3C, "R5");
        issue(0, 0, 1, 0, 0, 8'h00, "R5");

        // Random mix, checked against the reference state.
        for (int i = 0; i < 2000; i++) begin
            int sel = int'($urandom_range(0, 15));
            int a   = int'($urandom_range(0, 3));
            logic [W-1:0] d = W'($urandom);
            bit p  = (sel == 0);
            bit ra = (sel <= 3) || (sel == 15);
            bit ca = (sel >= 3);
            bit w  = (sel >= 10);
            issue(p, ra, ca, w, a, d, "R3");
        end
        issue(1, 0, 0, 0, 0, 8'h00, "R6");
        for (int r = 0; r < ROWS; r++) begin
            issue(0, 1, 0, 0, r, 8'h00, "R6");
            for (int c = 0; c < COLS; c++) issue(0, 0, 1, 0, c, 8'h00, "R6");
        end
        nop("R4");
        @(negedge clk);
        check_pending();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule